// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits beside the execute stage of a five-stage in-order pipeline. It decides, for each of the two ALU operands, whether the value read from the register file is current or whether a newer result must be taken from one of the two later pipeline registers. It compares the two source register numbers of the instruction now entering execute with the destination number and write enable of the instruction one stage ahead (the execute/memory register) and of the instruction two stages ahead (the memory/writeback register).

The outcome is one 2-bit select per operand. A newer producer wins over an older one when both write the same source, so a chain of dependent instructions always sees the most recent value. Register 0 is hard-wired to zero and is never bypassed, and a producer that does not write the register file is ignored. For test purposes the top also applies the selects to three 32-bit candidates per operand and presents the chosen operands. Everything is combinational; no clock or reset enters the block.

Top module: `exe_bypass_unit`

## Requirements
- R1: Select encoding is 2'b00 = register-file value, 2'b10 = execute/memory result, 2'b01 = memory/writeback result; 2'b11 never appears, and each operand output equals the candidate its select names.
- R2: Operand A select is 2'b10 when `exm_wen` is 1, `exm_dst` is nonzero and `exm_dst` equals `src_a`.
- R3: Operand B select is 2'b10 when `exm_wen` is 1, `exm_dst` is nonzero and `exm_dst` equals `src_b`.
- R4: An operand select is 2'b01 when `mwb_wen` is 1, `mwb_dst` is nonzero, `mwb_dst` equals that operand's source, and the R2/R3 condition for that operand is false.
- R5: When both producers write the same nonzero register that an operand reads, the select is 2'b10 (newest value wins).
- R6: A producer whose destination is 0 never causes a nonzero select, even with its write enable set.
- R7: A producer whose write enable is 0 never causes a nonzero select, even when its destination matches.
- R8: Operands A and B are resolved independently; in one cycle A may select 2'b10 while B selects 2'b01.
- R9: With no qualifying match, a select is 2'b00 and the operand output equals its register-file value.
- R10: Selects and operand outputs follow their inputs combinationally, without waiting for any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | 5 | First source register number of the instruction in execute |
| src_b | input | 5 | Second source register number of the instruction in execute |
| exm_wen | input | 1 | Register write enable of the execute/memory producer |
| exm_dst | input | 5 | Destination register of the execute/memory producer |
| mwb_wen | input | 1 | Register write enable of the memory/writeback producer |
| mwb_dst | input | 5 | Destination register of the memory/writeback producer |
| rf_val_a | input | 32 | Register-file value read for operand A |
| rf_val_b | input | 32 | Register-file value read for operand B |
| exm_val | input | 32 | Result held in the execute/memory register |
| mwb_val | input | 32 | Result held in the memory/writeback register |
| sel_a | output | 2 | Bypass select for operand A |
| sel_b | output | 2 | Bypass select for operand B |
| opnd_a | output | 32 | Chosen value for operand A |
| opnd_b | output | 32 | Chosen value for operand B |

## Verification
The assertions assume every input is a known 0/1 value whenever they are evaluated, and that the candidate values are what the selects are judged against rather than anything about their contents. The bench drives all inputs together on the falling edge of its own clock from fully defined vectors, using distinct 32-bit candidate patterns per source so that a wrong choice of operand is visible, and reads outputs one nanosecond later once the logic has settled.

// File: rtl/exe_bypass_pkg.sv
// Package: exe_bypass_pkg
// Shared select encoding for the execute-stage bypass logic.
// Assumes: the operand mux and the checker decode exactly these codes.
package exe_bypass_pkg;

    typedef enum logic [1:0] {
        BYP_RF  = 2'b00,   // register-file value is current
        BYP_WB  = 2'b01,   // take memory/writeback result
        BYP_MEM = 2'b10    // take execute/memory result
    } byp_sel_e;

endpackage

// File: rtl/byp_stage_match.sv
// Module: byp_stage_match
// Decides whether one later-stage producer holds a newer value for one source.
// Assumes: register 0 is constant zero and must never be bypassed.
module byp_stage_match #(
    parameter int ADDR_W = 5
) (
    input  logic              prod_wen,
    input  logic [ADDR_W-1:0] prod_dst,
    input  logic [ADDR_W-1:0] cons_src,
    output logic              hit
);

    localparam logic [ADDR_W-1:0] ZERO_REG = '0;

    // Qualify the address compare with write enable and the zero register.
    always_comb begin
        hit = prod_wen && (prod_dst != ZERO_REG) && (prod_dst == cons_src);
    end

endmodule

// File: rtl/byp_sel_resolve.sv
// Module: byp_sel_resolve
// Turns the two per-stage hits of one operand into a select code.
// Assumes: mem_hit comes from the younger producer and therefore has priority.
module byp_sel_resolve
    import exe_bypass_pkg::*;
(
    input  logic     mem_hit,
    input  logic     wb_hit,
    output byp_sel_e sel
);

    // Priority pick: newest producer first, register file last.
    always_comb begin
        if (mem_hit)     sel = BYP_MEM;
        else if (wb_hit) sel = BYP_WB;
        else             sel = BYP_RF;
    end

endmodule

// File: rtl/byp_operand_mux.sv
// Module: byp_operand_mux
// Applies a bypass select to three candidate values of one operand.
// Assumes: the unused code 2'b11 falls back to the register-file value.
module byp_operand_mux
    import exe_bypass_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] mem_val,
    input  logic [DATA_W-1:0] wb_val,
    output logic [DATA_W-1:0] dout
);

    // Decode the select into the chosen candidate.
    always_comb begin
        case (sel)
            BYP_MEM: dout = mem_val;
            BYP_WB:  dout = wb_val;
            default: dout = rf_val;
        endcase
    end

endmodule

// File: rtl/exe_bypass_unit.sv
// Module: exe_bypass_unit
// Execute-stage operand bypass selector for a five-stage pipeline, with a
// test wrapper that applies the selects to 32-bit candidates.
// Assumes: sources come from the decode/execute register, producers from the
// execute/memory and memory/writeback registers; fully combinational.
module exe_bypass_unit
    import exe_bypass_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0] src_a,
    input  logic [ADDR_W-1:0] src_b,
    input  logic              exm_wen,
    input  logic [ADDR_W-1:0] exm_dst,
    input  logic              mwb_wen,
    input  logic [ADDR_W-1:0] mwb_dst,
    input  logic [DATA_W-1:0] rf_val_a,
    input  logic [DATA_W-1:0] rf_val_b,
    input  logic [DATA_W-1:0] exm_val,
    input  logic [DATA_W-1:0] mwb_val,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);

    localparam int NUM_OPND = 2;

    logic [ADDR_W-1:0] src_arr  [NUM_OPND];
    logic [DATA_W-1:0] rf_arr   [NUM_OPND];
    logic [DATA_W-1:0] opnd_arr [NUM_OPND];
    logic [1:0]        sel_arr  [NUM_OPND];

    // Gather per-operand inputs into arrays for the generate loop.
    always_comb begin
        src_arr[0] = src_a;
        src_arr[1] = src_b;
        rf_arr[0]  = rf_val_a;
        rf_arr[1]  = rf_val_b;
    end

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        logic     mem_hit;
        logic     wb_hit;
        byp_sel_e sel_e;

        byp_stage_match #(.ADDR_W(ADDR_W)) u_mem_match (
            .prod_wen (exm_wen),
            .prod_dst (exm_dst),
            .cons_src (src_arr[g]),
            .hit      (mem_hit)
        );

        byp_stage_match #(.ADDR_W(ADDR_W)) u_wb_match (
            .prod_wen (mwb_wen),
            .prod_dst (mwb_dst),
            .cons_src (src_arr[g]),
            .hit      (wb_hit)
        );

        byp_sel_resolve u_resolve (
            .mem_hit (mem_hit),
            .wb_hit  (wb_hit),
            .sel     (sel_e)
        );

        assign sel_arr[g] = sel_e;

        byp_operand_mux #(.DATA_W(DATA_W)) u_mux (
            .sel     (sel_arr[g]),
            .rf_val  (rf_arr[g]),
            .mem_val (exm_val),
            .wb_val  (mwb_val),
            .dout    (opnd_arr[g])
        );
    end

    // Scatter per-operand results onto the ports.
    always_comb begin
        sel_a  = sel_arr[0];
        sel_b  = sel_arr[1];
        opnd_a = opnd_arr[0];
        opnd_b = opnd_arr[1];
    end

endmodule

// File: rtl/exe_bypass_unit_chk.sv
// Module: exe_bypass_unit_chk
// Checker bound to exe_bypass_unit; relates selects, sources and operands.
// Assumes: inputs are known values whenever the checks are evaluated.
module exe_bypass_unit_chk #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input logic [ADDR_W-1:0] src_a,
    input logic [ADDR_W-1:0] src_b,
    input logic              exm_wen,
    input logic [ADDR_W-1:0] exm_dst,
    input logic              mwb_wen,
    input logic [ADDR_W-1:0] mwb_dst,
    input logic [DATA_W-1:0] rf_val_a,
    input logic [DATA_W-1:0] rf_val_b,
    input logic [DATA_W-1:0] exm_val,
    input logic [DATA_W-1:0] mwb_val,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b
);

    // Check port-level relations whenever any observed value changes.
    always_comb begin
        AST_NO_ILLEGAL_SEL: assert (sel_a != 2'b11 && sel_b != 2'b11) else $error("illegal select"); // R1
        AST_OPND_A_FOLLOWS_SEL: assert (opnd_a == (sel_a == 2'b10 ? exm_val : sel_a == 2'b01 ? mwb_val : rf_val_a)) else $error("operand A mismatch"); // R1
        AST_OPND_B_FOLLOWS_SEL: assert (opnd_b == (sel_b == 2'b10 ? exm_val : sel_b == 2'b01 ? mwb_val : rf_val_b)) else $error("operand B mismatch"); // R1
        AST_MEM_A_NEEDS_MATCH: assert (sel_a != 2'b10 || (exm_wen && exm_dst == src_a)) else $error("A mem select without match"); // R2
        AST_MEM_B_NEEDS_MATCH: assert (sel_b != 2'b10 || (exm_wen && exm_dst == src_b)) else $error("B mem select without match"); // R3
        AST_WB_A_NEEDS_MATCH: assert (sel_a != 2'b01 || (mwb_wen && mwb_dst == src_a)) else $error("A wb select without match"); // R4
        AST_WB_B_NEEDS_MATCH: assert (sel_b != 2'b01 || (mwb_wen && mwb_dst == src_b)) else $error("B wb select without match"); // R4
        AST_NEWEST_WINS: assert (!(exm_wen && mwb_wen && exm_dst == mwb_dst && exm_dst != '0 && src_a == exm_dst) || sel_a == 2'b10) else $error("older value chosen"); // R5
        AST_ZERO_NEVER_BYPASSED: assert ((src_a != '0 || sel_a == 2'b00) && (src_b != '0 || sel_b == 2'b00)) else $error("register 0 bypassed"); // R6
        AST_IDLE_NO_BYPASS: assert ((exm_wen || mwb_wen) || (sel_a == 2'b00 && sel_b == 2'b00)) else $error("bypass with no writer"); // R7
    end

endmodule

bind exe_bypass_unit exe_bypass_unit_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_exe_bypass_unit_chk (
    .src_a    (src_a),
    .src_b    (src_b),
    .exm_wen  (exm_wen),
    .exm_dst  (exm_dst),
    .mwb_wen  (mwb_wen),
    .mwb_dst  (mwb_dst),
    .rf_val_a (rf_val_a),
    .rf_val_b (rf_val_b),
    .exm_val  (exm_val),
    .mwb_val  (mwb_val),
    .sel_a    (sel_a),
    .sel_b    (sel_b),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b)
);

// File: tb/test_exe_bypass_unit.sv
// Bench: directed scenarios for exe_bypass_unit; each task checks its own results.
module test_exe_bypass_unit;

    localparam logic [31:0] RFA = 32'hAAAA_0001;
    localparam logic [31:0] RFB = 32'hBBBB_0002;
    localparam logic [31:0] EXV = 32'hE0E0_0003;
    localparam logic [31:0] WBV = 32'hD0D0_0004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src_a, src_b, exm_dst, mwb_dst;
    logic        exm_wen, mwb_wen;
    logic [31:0] rf_val_a, rf_val_b, exm_val, mwb_val;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] opnd_a, opnd_b;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    exe_bypass_unit i_exe_bypass_unit (
        .src_a(src_a), .src_b(src_b),
        .exm_wen(exm_wen), .exm_dst(exm_dst),
        .mwb_wen(mwb_wen), .mwb_dst(mwb_dst),
        .rf_val_a(rf_val_a), .rf_val_b(rf_val_b),
        .exm_val(exm_val), .mwb_val(mwb_val),
        .sel_a(sel_a), .sel_b(sel_b),
        .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    // Compare one value and report a failure line when it differs.
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive a full input vector on the falling edge, then let it settle.
    task automatic drive(input logic [4:0] sa, input logic [4:0] sb,
                         input logic ew, input logic [4:0] ed,
                         input logic ww, input logic [4:0] wd);
        @(negedge clk);
        src_a = sa; src_b = sb;
        exm_wen = ew; exm_dst = ed;
        mwb_wen = ww; mwb_dst = wd;
        rf_val_a = RFA; rf_val_b = RFB; exm_val = EXV; mwb_val = WBV;
        #1;
    endtask

    task automatic t_reset_idle();
        drive(5'd3, 5'd4, 1'b0, 5'd0, 1'b0, 5'd0);
        chk("R9 sel_a idle", {30'd0, sel_a}, 32'd0);
        chk("R9 sel_b idle", {30'd0, sel_b}, 32'd0);
        chk("R9 opnd_a idle", opnd_a, RFA);
        chk("R9 opnd_b idle", opnd_b, RFB);
    endtask

    task automatic t_mem_a();
        drive(5'd3, 5'd4, 1'b1, 5'd3, 1'b0, 5'd0);
        chk("R2 sel_a", {30'd0, sel_a}, 32'd2);
        chk("R1 opnd_a mem", opnd_a, EXV);
        chk("R9 sel_b", {30'd0, sel_b}, 32'd0);
    endtask

    task automatic t_mem_b();
        drive(5'd6, 5'd17, 1'b1, 5'd17, 1'b0, 5'd0);
        chk("R3 sel_b", {30'd0, sel_b}, 32'd2);
        chk("R1 opnd_b mem", opnd_b, EXV);
        chk("R3 sel_a", {30'd0, sel_a}, 32'd0);
    endtask

    task automatic t_wb_a();
        drive(5'd7, 5'd8, 1'b1, 5'd9, 1'b1, 5'd7);
        chk("R4 sel_a", {30'd0, sel_a}, 32'd1);
        chk("R1 opnd_a wb", opnd_a, WBV);
    endtask

    // Three dependent adds to the same register: newest producer wins.
    task automatic t_double();
        drive(5'd1, 5'd2, 1'b1, 5'd1, 1'b1, 5'd1);
        chk("R5 sel_a", {30'd0, sel_a}, 32'd2);
        chk("R5 opnd_a", opnd_a, EXV);
        drive(5'd1, 5'd1, 1'b1, 5'd1, 1'b1, 5'd1);
        chk("R5 sel_b", {30'd0, sel_b}, 32'd2);
    endtask

    task automatic t_wen_clear();
        drive(5'd1, 5'd1, 1'b0, 5'd1, 1'b1, 5'd1);
        chk("R7 mem off wb used", {30'd0, sel_a}, 32'd1);
        drive(5'd5, 5'd5, 1'b0, 5'd5, 1'b0, 5'd5);
        chk("R7 sel_a", {30'd0, sel_a}, 32'd0);
        chk("R7 opnd_b", opnd_b, RFB);
    endtask

    task automatic t_zero_dst();
        drive(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0);
        chk("R6 sel_a", {30'd0, sel_a}, 32'd0);
        chk("R6 sel_b", {30'd0, sel_b}, 32'd0);
        chk("R6 opnd_a", opnd_a, RFA);
        drive(5'd0, 5'd12, 1'b1, 5'd0, 1'b1, 5'd12);
        chk("R6 zero mem lets wb", {30'd0, sel_b}, 32'd1);
    endtask

    task automatic t_independent();
        drive(5'd4, 5'd9, 1'b1, 5'd4, 1'b1, 5'd9);
        chk("R8 sel_a", {30'd0, sel_a}, 32'd2);
        chk("R8 sel_b", {30'd0, sel_b}, 32'd1);
        chk("R8 opnd_b", opnd_b, WBV);
    endtask

    // Change a source mid-cycle with no clock edge in between.
    task automatic t_comb();
        drive(5'd10, 5'd11, 1'b1, 5'd10, 1'b0, 5'd0);
        chk("R10 before", {30'd0, sel_a}, 32'd2);
        #2;
        src_a = 5'd11;
        #1;
        chk("R10 after", {30'd0, sel_a}, 32'd0);
        chk("R10 opnd", opnd_a, RFA);
    endtask

    // Watchdog: a hung run is a failed check and still reaches the summary.
    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_reset_idle();
        t_mem_a();
        t_mem_b();
        t_wb_a();
        t_double();
        t_wen_clear();
        t_zero_dst();
        t_independent();
        t_comb();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule